// File: doc/BRIEF.md
# Nonvolatile Command Unlock Detector

This block watches the accesses on an asynchronous-style SRAM bus, one event for each access strobe, and looks for a fixed series of six reads. The reads must come in a set order and with no other access between them. The first five read addresses are a shared unlock prefix. The address of the sixth read picks one of three nonvolatile commands: store, recall, or disable of the automatic store. When the series completes, the block raises a single-cycle command pulse and drives a 2-bit code with it. That pulse starts the matching operation in the rest of the memory controller.

The reads that form the key are ordinary reads. The detector only listens, so the data path is left alone. Only address bits 14 to 2 take part in the match. A write, or any read that is not the expected next step, abandons the series. The read that broke the series is then checked again as a possible first step. While the memory reports busy, the detector ignores the bus and holds its progress at zero.

Top module: `nv_unlock_det`

## Requirements
- R1: After reset, `cmd_valid` is 0 and no step is in progress. A reset that arrives part way through a series discards that series, so a later sixth-step read alone issues nothing.
- R2: The reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, with no other access between them, make `cmd_valid` 1 in the cycle after the sixth strobe, with `cmd_code` = 1 (store).
- R3: The same five-read prefix followed by a read at 0x4C63 gives `cmd_code` = 2 (recall).
- R4: The same prefix followed by a read at 0x8B45 gives `cmd_code` = 3 (automatic-store disable).
- R5: Only address bits [14:2] are compared. Flipping bit 16, bit 15, bit 1 or bit 0 of any step does not change the result.
- R6: An access with `acc_wr` = 1 anywhere in the series returns the detector to no progress, and no command follows from that series.
- R7: A read that is not the expected next step abandons the series, and no command is issued for it.
- R8: A read that breaks the series is checked as a possible step 1. If it matches 0x4E38, a series that continues from it completes normally.
- R9: A pulse on either `ce_stb` or `oe_stb` counts as one access. Pulses on both in the same cycle count as a single access. Cycles with neither strobe do not affect progress.
- R10: In any cycle with `busy` = 1, accesses are ignored, the progress returns to zero and no command is issued.
- R11: `cmd_valid` lasts exactly one cycle. After a command, progress is zero, so another sixth-step read alone issues nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_stb | input | 1 | Single-cycle pulse: access completed by chip-enable |
| oe_stb | input | 1 | Single-cycle pulse: access completed by output-enable |
| acc_wr | input | 1 | 1 when the strobed access is a write |
| busy | input | 1 | Memory reports a nonvolatile operation in progress |
| addr | input | ADDR_W (17) | Address of the strobed access |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command: 1 store, 2 recall, 3 automatic-store disable, 0 when idle |

## Verification
Two things can fall on the same strobe: the abort of a partly matched series and the start of a new one, because the offending read is checked again as step 1. The bench provokes this by repeating 0xB1C7's predecessor 0x4E38 at the second step and then finishing the series. Only a command issued at the end shows that both effects happened in that one cycle. A second pairing sets `busy` on the same cycle as a valid step. There the bench expects the step to be dropped and the following steps to produce no command.

// File: rtl/nvu_pkg.sv
package nvu_pkg;

  localparam int NUM_KEYS   = 8;   // five prefix steps, three final selectors
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = 3;

  localparam logic [1:0] CMD_NONE   = 2'd0;
  localparam logic [1:0] CMD_STORE  = 2'd1;
  localparam logic [1:0] CMD_RECALL = 2'd2;
  localparam logic [1:0] CMD_ASDIS  = 2'd3;

  // Key address for each slot: slots 0..4 are the shared prefix in order,
  // slots 5..7 select store, recall and automatic-store disable.
  function automatic logic [15:0] key_addr(input int idx);
    case (idx)
      0:       key_addr = 16'h4E38;
      1:       key_addr = 16'hB1C7;
      2:       key_addr = 16'h83E0;
      3:       key_addr = 16'h7C1F;
      4:       key_addr = 16'h703F;
      5:       key_addr = 16'h8FC0;
      6:       key_addr = 16'h4C63;
      default: key_addr = 16'h8B45;
    endcase
  endfunction

endpackage

// File: rtl/nvu_key_match.sv
module nvu_key_match #(
  parameter int ADDR_W = 17,
  parameter int CMP_LO = 2,
  parameter int CMP_HI = 14
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic [nvu_pkg::NUM_KEYS-1:0] hit
);
  // Ones only across the compared slice; every other bit is a don't-care.
  localparam logic [ADDR_W-1:0] CMP_MASK =
    ADDR_W'(((ADDR_W'(1) << (CMP_HI - CMP_LO + 1)) - ADDR_W'(1)) << CMP_LO);

  for (genvar g = 0; g < nvu_pkg::NUM_KEYS; g++) begin : g_key
    localparam logic [15:0]       KEY16 = nvu_pkg::key_addr(g);
    localparam logic [ADDR_W-1:0] KEY   = ADDR_W'(KEY16);
    assign hit[g] = ((addr ^ KEY) & CMP_MASK) == '0;
  end

endmodule

// File: rtl/nvu_step_ctr.sv
module nvu_step_ctr
  import nvu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic                acc_wr,
  input  logic                busy,
  input  logic [NUM_KEYS-1:0] hit,
  output logic [STEP_W-1:0]   step_q,
  output logic                cmd_valid_q,
  output logic [1:0]          cmd_code_q
);
  localparam logic [STEP_W-1:0] LAST_PREFIX = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0] step_d;
  logic [STEP_W-1:0] restart_v;
  logic              step_en;
  logic              fire_d;
  logic [1:0]        code_d;

  assign step_en   = busy | acc;
  assign restart_v = hit[0] ? STEP_W'(1) : '0;

  always_comb begin
    step_d = step_q;
    fire_d = 1'b0;
    code_d = CMD_NONE;
    if (busy) begin
      step_d = '0;
    end else if (acc) begin
      if (acc_wr) begin
        step_d = '0;
      end else if (step_q == LAST_PREFIX) begin
        if (hit[5])      code_d = CMD_STORE;
        else if (hit[6]) code_d = CMD_RECALL;
        else if (hit[7]) code_d = CMD_ASDIS;
        fire_d = (code_d != CMD_NONE);
        step_d = fire_d ? '0 : restart_v;
      end else if (hit[step_q]) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = restart_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_code_q  <= CMD_NONE;
    end else begin
      cmd_valid_q <= fire_d;
      cmd_code_q  <= code_d;
    end
  end

  // R7: progress never runs past the last prefix step
  assert_step_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_PREFIX);

  // R6: a write clears progress
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_wr && !busy) |=> (step_q == '0 && !cmd_valid_q));

  // R10: busy clears progress and blocks commands
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step_q == '0 && !cmd_valid_q));

  // R11: command pulse is a single cycle
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_q |=> !cmd_valid_q);

  // R2: a command only follows a full prefix and carries a real code
  assert_cmd_after_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_q |-> ($past(step_q) == LAST_PREFIX && cmd_code_q != CMD_NONE));

endmodule

// File: rtl/nv_unlock_det.sv
module nv_unlock_det #(
  parameter int ADDR_W = 17,
  parameter int CMP_LO = 2,
  parameter int CMP_HI = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_stb,
  input  logic              oe_stb,
  input  logic              acc_wr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code
);
  import nvu_pkg::*;

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                acc;
  logic [NUM_KEYS-1:0] hit;
  logic [STEP_W-1:0]   step_q;

  // Asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc = ce_stb | oe_stb;

  nvu_key_match #(
    .ADDR_W(ADDR_W),
    .CMP_LO(CMP_LO),
    .CMP_HI(CMP_HI)
  ) u_match (
    .addr(addr),
    .hit (hit)
  );

  nvu_step_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .acc        (acc),
    .acc_wr     (acc_wr),
    .busy       (busy),
    .hit        (hit),
    .step_q     (step_q),
    .cmd_valid_q(cmd_valid),
    .cmd_code_q (cmd_code)
  );

  // R9: cycles without a strobe leave progress untouched unless busy
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!acc && !busy) |=> $stable(step_q));

  // R1: code reads idle whenever no pulse is present
  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmd_valid |-> (cmd_code == CMD_NONE));

endmodule

// File: tb/sim_nv_unlock_det.sv
`timescale 1ns/1ps
module sim_nv_unlock_det;

  typedef struct packed {
    logic        ce;
    logic        oe;
    logic        wr;
    logic        bz;
    logic [16:0] a;
    logic        ev;
    logic [1:0]  ec;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t rd(input logic [16:0] a, input logic ev,
                              input logic [1:0] ec, input logic [3:0] rq);
    rd = '{1'b1, 1'b0, 1'b0, 1'b0, a, ev, ec, rq};
  endfunction
  function automatic vec_t ro(input logic [16:0] a, input logic ev,
                              input logic [1:0] ec, input logic [3:0] rq);
    ro = '{1'b0, 1'b1, 1'b0, 1'b0, a, ev, ec, rq};
  endfunction
  function automatic vec_t rb(input logic [16:0] a, input logic [3:0] rq);
    rb = '{1'b1, 1'b1, 1'b0, 1'b0, a, 1'b0, 2'd0, rq};
  endfunction
  function automatic vec_t wv(input logic [16:0] a, input logic [3:0] rq);
    wv = '{1'b1, 1'b0, 1'b1, 1'b0, a, 1'b0, 2'd0, rq};
  endfunction
  function automatic vec_t bzv(input logic [16:0] a, input logic [3:0] rq);
    bzv = '{1'b1, 1'b0, 1'b0, 1'b1, a, 1'b0, 2'd0, rq};
  endfunction
  function automatic vec_t idl(input logic [3:0] rq);
    idl = '{1'b0, 1'b0, 1'b0, 1'b0, 17'h0, 1'b0, 2'd0, rq};
  endfunction

  localparam logic [16:0] K1 = 17'h04E38, K2 = 17'h0B1C7, K3 = 17'h083E0,
                          K4 = 17'h07C1F, K5 = 17'h0703F;
  localparam int NV = 62;
  localparam vec_t TAB [NV] = '{
    // R2 store, with an idle cycle inside (R9)
    rd(K1,0,0,2), rd(K2,0,0,2), idl(9), rd(K3,0,0,2), rd(K4,0,0,2),
    rd(K5,0,0,2), rd(17'h08FC0,1,1,2), idl(11),
    // R3 recall, output-enable strobes (R9)
    ro(K1,0,0,3), ro(K2,0,0,3), ro(K3,0,0,3), ro(K4,0,0,3), ro(K5,0,0,3),
    ro(17'h04C63,1,2,3),
    // R4 disable, both strobes together count once (R9)
    rb(K1,9), rd(K2,0,0,4), rd(K3,0,0,4), rd(K4,0,0,4), rd(K5,0,0,4),
    rd(17'h08B45,1,3,4),
    // R5 bits outside [14:2] flipped
    rd(17'h1CE3B,0,0,5), rd(17'h031C7,0,0,5), rd(17'h083E1,0,0,5),
    rd(17'h0FC1D,0,0,5), rd(17'h1703F,0,0,5), rd(17'h00FC3,1,1,5),
    // R6 write inside the series
    rd(K1,0,0,6), rd(K2,0,0,6), wv(K3,6), rd(K3,0,0,6), rd(K4,0,0,6),
    rd(K5,0,0,6), rd(17'h08FC0,0,0,6),
    // R7 stray read
    rd(K1,0,0,7), rd(K2,0,0,7), rd(K3,0,0,7), rd(17'h01234,0,0,7),
    rd(K4,0,0,7), rd(K5,0,0,7), rd(17'h04C63,0,0,7),
    // R8 abort and restart on the same read
    rd(K1,0,0,8), rd(K2,0,0,8), rd(K1,0,0,8), rd(K2,0,0,8), rd(K3,0,0,8),
    rd(K4,0,0,8), rd(K5,0,0,8), rd(17'h08B45,1,3,8),
    // R10 busy on a valid step
    rd(K1,0,0,10), rd(K2,0,0,10), bzv(K3,10), rd(K4,0,0,10),
    rd(K5,0,0,10), rd(17'h08FC0,0,0,10), idl(10),
    // R11 progress cleared after a command
    rd(K1,0,0,11), rd(K2,0,0,11), rd(K3,0,0,11), rd(K4,0,0,11),
    rd(K5,0,0,11), rd(17'h08FC0,1,1,11), rd(17'h08FC0,0,0,11)
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_stb, oe_stb, acc_wr, busy;
  logic [16:0] addr;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  nv_unlock_det u0 (
    .clk(clk), .rst_n(rst_n), .ce_stb(ce_stb), .oe_stb(oe_stb),
    .acc_wr(acc_wr), .busy(busy), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ev, input logic [1:0] ec, input int rq);
    total = total + 1;
    if (cmd_valid !== ev || cmd_code !== ec) begin
      bad = bad + 1;
      $display("FAIL R%0d valid=%0b code=%0d expected valid=%0b code=%0d",
               rq, cmd_valid, cmd_code, ev, ec);
    end
  endtask

  task automatic apply(input vec_t v);
    ce_stb = v.ce; oe_stb = v.oe; acc_wr = v.wr; busy = v.bz; addr = v.a;
    @(negedge clk);
    ce_stb = 1'b0; oe_stb = 1'b0; acc_wr = 1'b0; busy = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    ce_stb = 0; oe_stb = 0; acc_wr = 0; busy = 0; addr = '0;
    @(negedge clk);
    do_reset();
    chk(1'b0, 2'd0, 1);   // R1 reset state
    apply(rd(17'h08FC0,0,0,1));
    chk(1'b0, 2'd0, 1);   // R1 no progress out of reset

    for (int i = 0; i < NV; i++) begin
      apply(TAB[i]);
      chk(TAB[i].ev, TAB[i].ec, int'(TAB[i].rq));
    end

    // R1: reset in the middle of a series
    apply(rd(K1,0,0,1)); apply(rd(K2,0,0,1)); apply(rd(K3,0,0,1));
    apply(rd(K4,0,0,1)); apply(rd(K5,0,0,1));
    do_reset();
    chk(1'b0, 2'd0, 1);
    apply(rd(17'h08FC0,0,0,1));
    chk(1'b0, 2'd0, 1);   // R1 sixth step alone after reset

    // R11: pulse gone on the following cycle after a full series
    apply(rd(K1,0,0,11)); apply(rd(K2,0,0,11)); apply(rd(K3,0,0,11));
    apply(rd(K4,0,0,11)); apply(rd(K5,0,0,11));
    apply(rd(17'h04C63,0,0,11));
    chk(1'b1, 2'd2, 11);
    @(negedge clk);
    chk(1'b0, 2'd0, 11);  // R11 single cycle

    // R10: busy alone after a partial series leaves nothing behind
    apply(rd(K1,0,0,10)); apply(rd(K2,0,0,10)); apply(rd(K3,0,0,10));
    apply(rd(K4,0,0,10)); apply(rd(K5,0,0,10));
    busy = 1'b1; @(negedge clk); busy = 1'b0;
    apply(rd(17'h08B45,0,0,10));
    chk(1'b0, 2'd0, 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule